// File: doc/BRIEF.md
# Configuration Bit-Flip Fault Injector

This block emulates radiation upsets in the configuration memory of a programmable device. Each injection picks a pseudo-random frame and a pseudo-random bit inside that frame. It copies the whole frame out of the device into a local buffer over the configuration port, inverts that one bit, and writes the frame back. A run of several faults is a series of such single-bit injections, one after another.

The configuration port is shared with a scrubber, and only one of them may drive it at a time. The injector raises a request and waits for a grant before it touches the port. It drops the request as soon as the write-back of the frame is finished. A small command interface takes a seed, a fault count and a start strobe. For logging, it reports the frame and bit of every injection and raises a done flag when the run is over. This interface stands in for the serial command link.

Top module: `cfg_flip_injector`

## Requirements
- R1: While reset is asserted and right after it, `port_req`, `cfg_en`, `rep_valid` and `done` are low.
- R2: The random source is a 32-bit register that shifts left, taking as its new bit 0 the XOR of its bits 31, 21, 1 and 0. After reset it holds 1. A pulse on `seed_load` loads `seed_val`, except that a zero seed loads 1. The register advances exactly once per injection, before that injection's indices are taken.
- R3: For each injection the frame index is (bits 15:0 of the advanced register) modulo FRAME_COUNT. The bit index is (bits 31:16) modulo FRAME_WORDS*32.
- R4: `port_req` goes high before any port access. `cfg_en` is high only while `port_grant` is high. While the grant is withheld, the injector makes no access and completes no injection.
- R5: An injection reads every word of the chosen frame and writes every word back. The written frame differs from the read frame only in word (bit index / 32), bit (bit index % 32). No other frame is written.
- R6: After the last write-back word, `port_req` falls and `rep_valid` pulses high for exactly one cycle. In that cycle `rep_frame` and `rep_bit` carry the injection's indices.
- R7: A `start` pulse while idle runs `inj_count` injections and then sets `done`. With `inj_count` equal to 0, `done` is set on the next cycle and no injection takes place.
- R8: `start` is ignored while a run is in progress. `done` stays high until the next accepted `start`.
- R9: Read data on `cfg_rdata` is taken one cycle after the cycle in which `cfg_en` is high with `cfg_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Load `seed_val` into the random source |
| seed_val | input | 32 | Seed value |
| start | input | 1 | Begin a run |
| inj_count | input | CNT_W | Number of injections in the run |
| done | output | 1 | Run finished |
| port_req | output | 1 | Request to own the configuration port |
| port_grant | input | 1 | Ownership granted by the arbiter |
| cfg_en | output | 1 | Configuration port access strobe |
| cfg_we | output | 1 | Access is a write |
| cfg_frame | output | FRAME_AW | Frame index of the access |
| cfg_word | output | WORD_AW | Word index within the frame |
| cfg_wdata | output | 32 | Write data |
| cfg_rdata | input | 32 | Read data, one cycle after a read |
| rep_valid | output | 1 | Injection report strobe |
| rep_frame | output | FRAME_AW | Frame index of the finished injection |
| rep_bit | output | BIT_W | Bit index of the finished injection |

## Verification
The bound checker holds the following on every cycle:
- port strobes only under request and grant;
- word indices stay within the frame;
- reported indices stay in range;
- the report lasts a single cycle and comes with the port released;
- the request falls only right after a write;
- a set done flag persists until a new start.

Other properties only the bench's scenarios can show. These are whether the indices follow the shift-register sequence and the modulo rule, and whether the frame that comes back differs in exactly the chosen bit. Also scenario-only are the treatment of a zero seed and a zero count, and stalling under a withheld or toggling grant. The bench shows them by keeping its own copy of the device memory and of the random sequence.

// File: rtl/flip_pkg.sv
package flip_pkg;

  localparam int RND_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICK,
    ST_WAIT,
    ST_RD_REQ,
    ST_RD_CAP,
    ST_FLIP,
    ST_WR,
    ST_REPORT
  } inj_state_t;

  // Fibonacci shift-left step, taps at bits 31, 21, 1, 0
  function automatic logic [RND_W-1:0] rnd_advance(input logic [RND_W-1:0] s);
    return {s[RND_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

endpackage

// File: rtl/flip_lfsr.sv
module flip_lfsr
  import flip_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RND_W-1:0] seed,
  input  logic             step,
  output logic [RND_W-1:0] state
);

  logic [RND_W-1:0] q, q_n;

  always_comb begin
    q_n = q;
    if (load)      q_n = (seed == '0) ? RND_W'(1) : seed;
    else if (step) q_n = rnd_advance(q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            q <= RND_W'(1);
    else if (load || step) q <= q_n;
  end

  assign state = q;

endmodule

// File: rtl/flip_frame_buf.sv
module flip_frame_buf #(
  parameter int WORDS = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic             flip_en,
  input  logic [IDX_W-1:0] flip_word,
  input  logic [4:0]       flip_pos,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_data
);

  logic [31:0] word_q [WORDS];

  for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
    logic        we_l, fe_l;
    logic [31:0] d_l;
    assign we_l = wr_en && (wr_idx == IDX_W'(gi));
    assign fe_l = flip_en && (flip_word == IDX_W'(gi));
    assign d_l  = we_l ? wr_data : (word_q[gi] ^ (32'h1 << flip_pos));
    always_ff @(posedge clk) begin
      if (we_l || fe_l) word_q[gi] <= d_l;
    end
  end

  always_comb begin
    rd_data = word_q[0];
    for (int i = 0; i < WORDS; i++)
      if (rd_idx == IDX_W'(i)) rd_data = word_q[i];
  end

endmodule

// File: rtl/flip_ctrl.sv
module flip_ctrl
  import flip_pkg::*;
#(
  parameter int FRAME_COUNT = 6,
  parameter int FRAME_WORDS = 3,
  parameter int CNT_W       = 8,
  parameter int FRAME_AW    = 3,
  parameter int WORD_AW     = 2,
  parameter int BIT_W       = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CNT_W-1:0]    inj_count,
  input  logic [RND_W-1:0]    rnd,
  output logic                rnd_step,
  input  logic                port_grant,
  output logic                port_req,
  output logic                cfg_en,
  output logic                cfg_we,
  output logic [WORD_AW-1:0]  wcnt,
  output logic                buf_wr,
  output logic                flip_en,
  output logic                rep_valid,
  output logic [FRAME_AW-1:0] sel_frame,
  output logic [BIT_W-1:0]    sel_bit,
  output logic                done
);

  localparam int FRAME_BITS = FRAME_WORDS * 32;
  localparam logic [WORD_AW-1:0] LAST_W = WORD_AW'(FRAME_WORDS - 1);

  inj_state_t          st_q, st_n;
  logic [WORD_AW-1:0]  wcnt_q, wcnt_n;
  logic [CNT_W-1:0]    rem_q, rem_n;
  logic [FRAME_AW-1:0] frm_q, frm_n;
  logic [BIT_W-1:0]    bit_q, bit_n;
  logic                done_q, done_n;
  logic [15:0]         frm_mod, bit_mod;

  assign frm_mod = 16'(rnd[15:0]  % 16'(FRAME_COUNT));
  assign bit_mod = 16'(rnd[31:16] % 16'(FRAME_BITS));

  always_comb begin
    st_n     = st_q;
    wcnt_n   = wcnt_q;
    rem_n    = rem_q;
    frm_n    = frm_q;
    bit_n    = bit_q;
    done_n   = done_q;
    rnd_step = 1'b0;
    buf_wr   = 1'b0;
    flip_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        rem_n  = inj_count;
        done_n = (inj_count == '0);
        if (inj_count != '0) st_n = ST_PICK;
      end
      ST_PICK: begin
        rnd_step = 1'b1;
        st_n     = ST_WAIT;
      end
      ST_WAIT: begin
        frm_n = frm_mod[FRAME_AW-1:0];
        bit_n = bit_mod[BIT_W-1:0];
        if (port_grant) begin
          wcnt_n = '0;
          st_n   = ST_RD_REQ;
        end
      end
      ST_RD_REQ: if (port_grant) st_n = ST_RD_CAP;
      ST_RD_CAP: begin
        buf_wr = 1'b1;
        if (wcnt_q == LAST_W) st_n = ST_FLIP;
        else begin
          wcnt_n = wcnt_q + 1'b1;
          st_n   = ST_RD_REQ;
        end
      end
      ST_FLIP: begin
        flip_en = 1'b1;
        wcnt_n  = '0;
        st_n    = ST_WR;
      end
      ST_WR: if (port_grant) begin
        if (wcnt_q == LAST_W) st_n = ST_REPORT;
        else wcnt_n = wcnt_q + 1'b1;
      end
      ST_REPORT: begin
        rem_n = rem_q - 1'b1;
        if (rem_q == CNT_W'(1)) begin
          done_n = 1'b1;
          st_n   = ST_IDLE;
        end else begin
          st_n = ST_PICK;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wcnt_q <= '0;
      rem_q  <= '0;
      frm_q  <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      wcnt_q <= wcnt_n;
      rem_q  <= rem_n;
      frm_q  <= frm_n;
      bit_q  <= bit_n;
      done_q <= done_n;
    end
  end

  assign port_req  = (st_q == ST_WAIT) || (st_q == ST_RD_REQ) || (st_q == ST_RD_CAP) ||
                     (st_q == ST_FLIP) || (st_q == ST_WR);
  assign cfg_en    = port_grant && ((st_q == ST_RD_REQ) || (st_q == ST_WR));
  assign cfg_we    = (st_q == ST_WR);
  assign rep_valid = (st_q == ST_REPORT);
  assign wcnt      = wcnt_q;
  assign sel_frame = frm_q;
  assign sel_bit   = bit_q;
  assign done      = done_q;

endmodule

// File: rtl/cfg_flip_injector.sv
module cfg_flip_injector
  import flip_pkg::*;
#(
  parameter int FRAME_COUNT = 6,
  parameter int FRAME_WORDS = 3,
  parameter int CNT_W       = 8,
  localparam int FRAME_AW   = (FRAME_COUNT > 1) ? $clog2(FRAME_COUNT) : 1,
  localparam int WORD_AW    = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1,
  localparam int BIT_W      = WORD_AW + 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                seed_load,
  input  logic [31:0]         seed_val,
  input  logic                start,
  input  logic [CNT_W-1:0]    inj_count,
  output logic                done,
  output logic                port_req,
  input  logic                port_grant,
  output logic                cfg_en,
  output logic                cfg_we,
  output logic [FRAME_AW-1:0] cfg_frame,
  output logic [WORD_AW-1:0]  cfg_word,
  output logic [31:0]         cfg_wdata,
  input  logic [31:0]         cfg_rdata,
  output logic                rep_valid,
  output logic [FRAME_AW-1:0] rep_frame,
  output logic [BIT_W-1:0]    rep_bit
);

  logic [RND_W-1:0]    rnd;
  logic                rnd_step, buf_wr, flip_en;
  logic [WORD_AW-1:0]  wcnt;
  logic [FRAME_AW-1:0] sel_frame;
  logic [BIT_W-1:0]    sel_bit;

  flip_lfsr rnd_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (seed_load),
    .seed  (seed_val),
    .step  (rnd_step),
    .state (rnd)
  );

  flip_ctrl #(
    .FRAME_COUNT (FRAME_COUNT),
    .FRAME_WORDS (FRAME_WORDS),
    .CNT_W       (CNT_W),
    .FRAME_AW    (FRAME_AW),
    .WORD_AW     (WORD_AW),
    .BIT_W       (BIT_W)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .inj_count  (inj_count),
    .rnd        (rnd),
    .rnd_step   (rnd_step),
    .port_grant (port_grant),
    .port_req   (port_req),
    .cfg_en     (cfg_en),
    .cfg_we     (cfg_we),
    .wcnt       (wcnt),
    .buf_wr     (buf_wr),
    .flip_en    (flip_en),
    .rep_valid  (rep_valid),
    .sel_frame  (sel_frame),
    .sel_bit    (sel_bit),
    .done       (done)
  );

  flip_frame_buf #(
    .WORDS (FRAME_WORDS),
    .IDX_W (WORD_AW)
  ) buf_i (
    .clk       (clk),
    .wr_en     (buf_wr),
    .wr_idx    (wcnt),
    .wr_data   (cfg_rdata),
    .flip_en   (flip_en),
    .flip_word (sel_bit[BIT_W-1:5]),
    .flip_pos  (sel_bit[4:0]),
    .rd_idx    (wcnt),
    .rd_data   (cfg_wdata)
  );

  assign cfg_frame = sel_frame;
  assign cfg_word  = wcnt;
  assign rep_frame = sel_frame;
  assign rep_bit   = sel_bit;

endmodule

// File: rtl/flip_injector_chk.sv
module flip_injector_chk #(
  parameter int FRAME_COUNT = 6,
  parameter int FRAME_WORDS = 3,
  parameter int CNT_W       = 8,
  localparam int FRAME_AW   = (FRAME_COUNT > 1) ? $clog2(FRAME_COUNT) : 1,
  localparam int WORD_AW    = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1,
  localparam int BIT_W      = WORD_AW + 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                done,
  input logic                port_req,
  input logic                port_grant,
  input logic                cfg_en,
  input logic                cfg_we,
  input logic [WORD_AW-1:0]  cfg_word,
  input logic                rep_valid,
  input logic [FRAME_AW-1:0] rep_frame,
  input logic [BIT_W-1:0]    rep_bit
);

  assert_en_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> (port_req && port_grant));

  assert_word_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> (int'(cfg_word) < FRAME_WORDS));

  assert_rep_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> ((int'(rep_frame) < FRAME_COUNT) && (int'(rep_bit) < FRAME_WORDS * 32)));

  assert_rep_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |=> !rep_valid);

  assert_rep_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> !port_req);

  assert_release_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(port_req) |-> $past(cfg_en && cfg_we));

  assert_done_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

endmodule

bind cfg_flip_injector flip_injector_chk #(
  .FRAME_COUNT (FRAME_COUNT),
  .FRAME_WORDS (FRAME_WORDS),
  .CNT_W       (CNT_W)
) chk_i (.*);

// File: tb/cfg_flip_injector_tb_top.sv
module cfg_flip_injector_tb_top;

  localparam int FC    = 6;
  localparam int FW    = 3;
  localparam int CW    = 8;
  localparam int FAW   = 3;
  localparam int WAW   = 2;
  localparam int BW    = 7;
  localparam int FBITS = FW * 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           seed_load = 1'b0;
  logic [31:0]    seed_val = '0;
  logic           start = 1'b0;
  logic [CW-1:0]  inj_count = '0;
  logic           done, port_req, cfg_en, cfg_we, rep_valid;
  logic           port_grant = 1'b1;
  logic [FAW-1:0] cfg_frame, rep_frame;
  logic [WAW-1:0] cfg_word;
  logic [31:0]    cfg_wdata;
  logic [31:0]    cfg_rdata = '0;
  logic [BW-1:0]  rep_bit;

  int checks = 0;
  int fails  = 0;

  cfg_flip_injector #(.FRAME_COUNT(FC), .FRAME_WORDS(FW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_val(seed_val),
    .start(start), .inj_count(inj_count), .done(done), .port_req(port_req),
    .port_grant(port_grant), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .cfg_frame(cfg_frame), .cfg_word(cfg_word), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .rep_valid(rep_valid), .rep_frame(rep_frame),
    .rep_bit(rep_bit)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // device memory model and expected image
  logic [31:0] mem [FC][FW];
  logic [31:0] img [FC][FW];

  always @(posedge clk) begin
    if (cfg_en && !cfg_we) cfg_rdata <= mem[cfg_frame][cfg_word];
    if (cfg_en && cfg_we)  mem[cfg_frame][cfg_word] <= cfg_wdata;
  end

  // grant driver: 0 always granted, 1 toggling, 2 withheld
  int gmode = 0;
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    #2;
    port_grant = (gmode == 0) ? 1'b1 : ((gmode == 1) ? ((cyc % 5) != 0 && (cyc % 7) != 3) : 1'b0);
  end

  function automatic logic [31:0] model_step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  logic [31:0] m_rnd = 32'h1;
  int rep_cnt = 0;
  int grant_viol = 0;
  logic prev_rep = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cfg_en && !port_grant) grant_viol++;
      if (rep_valid) begin
        int ef, eb, mism;
        m_rnd = model_step(m_rnd);
        ef = int'(m_rnd[15:0]) % FC;
        eb = int'(m_rnd[31:16]) % FBITS;
        rep_cnt++;
        check(int'(rep_frame) == ef, "R3", "frame index", rep_frame, ef);
        check(int'(rep_bit) == eb, "R2", "bit index", rep_bit, eb);
        check(!port_req && !prev_rep, "R6", "released single pulse",
              {port_req, prev_rep}, 0);
        img[ef][eb / 32] = img[ef][eb / 32] ^ (32'h1 << (eb % 32));
        mism = 0;
        for (int w = 0; w < FW; w++) if (mem[ef][w] != img[ef][w]) mism++;
        check(mism == 0, "R5", "frame after write-back", mism, 0);
      end
      prev_rep = rep_valid;
    end
  end

  task automatic load_seed(input logic [31:0] s);
    @(negedge clk);
    seed_val  = s;
    seed_load = 1'b1;
    @(negedge clk);
    seed_load = 1'b0;
    m_rnd = (s == 0) ? 32'h1 : s;
  endtask

  task automatic image_check(input string req);
    int mism = 0;
    for (int f = 0; f < FC; f++)
      for (int w = 0; w < FW; w++) if (mem[f][w] != img[f][w]) mism++;
    check(mism == 0, req, "whole memory image", mism, 0);
  endtask

  task automatic run(input int cnt, input bit restart);
    int t = 0;
    rep_cnt = 0;
    @(negedge clk);
    inj_count = CW'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(cnt == 0 ? done : !done, "R7", "done after start", done, cnt == 0);
    if (restart) begin
      repeat (20) @(negedge clk);
      inj_count = 3;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    check(done, "R7", "done reached", done, 1);
    check(rep_cnt == cnt, restart ? "R8" : "R7", "injection count", rep_cnt, cnt);
    image_check("R9");
    repeat (5) @(negedge clk);
    check(done && !port_req, "R8", "done held, port released", {done, port_req}, 2'b10);
  endtask

  initial begin
    for (int f = 0; f < FC; f++)
      for (int w = 0; w < FW; w++) begin
        mem[f][w] = 32'h9E3779B9 * (f * FW + w + 1);
        img[f][w] = 32'h9E3779B9 * (f * FW + w + 1);
      end
    repeat (3) @(negedge clk);
    check(!port_req && !cfg_en && !rep_valid && !done, "R1", "outputs in reset",
          {port_req, cfg_en, rep_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!port_req && !cfg_en && !rep_valid && !done, "R1", "outputs after reset",
          {port_req, cfg_en, rep_valid, done}, 0);

    // R2: reset value of the random source is 1
    run(4, 1'b0);
    // R7: zero count
    run(0, 1'b0);
    check(rep_cnt == 0, "R7", "no injection for zero count", rep_cnt, 0);

    // sweep seeds and counts, with steady and toggling grant
    for (int g = 0; g < 2; g++) begin
      gmode = g;
      foreach (seed_tab[i]) begin
        load_seed(seed_tab[i]);
        run(1, 1'b0);
        run(9, 1'b0);
        run(30, 1'b0);
      end
    end
    gmode = 0;

    // R2: zero seed behaves as seed 1
    load_seed(32'h0);
    run(12, 1'b0);

    // R8: start during a run is ignored
    load_seed(32'h5A5A1234);
    run(10, 1'b1);

    // R4: grant withheld stalls the injector
    gmode = 2;
    rep_cnt = 0;
    @(negedge clk);
    inj_count = 2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    check(port_req && !cfg_en && rep_cnt == 0, "R4", "stalled without grant",
          {port_req, cfg_en, rep_cnt[0]}, 3'b100);
    image_check("R4");
    gmode = 0;
    repeat (200) @(negedge clk);
    check(done && rep_cnt == 2, "R4", "completes after grant", rep_cnt, 2);
    image_check("R5");
    check(grant_viol == 0, "R4", "access without grant", grant_viol, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  logic [31:0] seed_tab [4] = '{32'h1, 32'hACE1, 32'hDEADBEEF, 32'h12345678};

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule